// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block takes a DDR4-style memory device from power-on to the point where normal traffic may begin. After reset it keeps the device's clock-enable low for a programmable number of cycles, which covers the supply-settling interval. It then waits for an external indication that the memory clock is running, and only then drives clock-enable high.

With clock-enable high, it writes mode registers 0 to 7 in ascending order. Each value comes from a parameter table. Each command is held on the command outputs until the consumer accepts it, and a fixed idle gap follows every accepted command. After the last mode-register write and its gap, the sequencer issues one impedance (ZQ) calibration command. It then waits a programmable number of cycles and raises a done flag. The done flag stays high until the next reset.

Read and write commands never leave this block. The memory controller's scheduler is expected to hold off all traffic until the done flag is set.

Top module: `dram_init_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, `cke`, `cmdValid` and `initDone` are 0 after that edge, and the sequence restarts from the clock-enable-low interval.
- R2: `cke` stays 0 for at least HOLD_CYCLES cycles after reset is released. If `clkStable` is already 1, `cke` becomes 1 exactly HOLD_CYCLES+1 rising edges after release.
- R3: After the hold interval, `cke` stays 0 for as long as `clkStable` is 0. It becomes 1 after the first rising edge at which `clkStable` is 1.
- R4: Mode-register writes carry `cmdCode` 3'b001, `cmdReg` equal to the register index, and `cmdData` equal to entry `cmdReg` of MR_INIT. They are issued in index order 0, 1, …, 7, and only while `cke` is 1.
- R5: While `cmdValid` is 1 and `cmdAccept` is 0, the values of `cmdValid`, `cmdCode`, `cmdReg` and `cmdData` are held to the next cycle.
- R6: A command is accepted at a rising edge where both `cmdValid` and `cmdAccept` are 1. After that edge `cmdValid` is 0 for exactly GAP_CYCLES cycles before the next command. A `cmdAccept` that arrives while `cmdValid` is 0 has no effect.
- R7: After the gap that follows the last mode-register write, one calibration command with `cmdCode` 3'b010 is issued.
- R8: `initDone` becomes 1 exactly ZQ_CYCLES rising edges after the calibration command is accepted. It then stays 1 until reset, with `cmdValid` held at 0.
- R9: `cmdCode` is 3'b000 whenever `cmdValid` is 0. No code other than 3'b001 or 3'b010 is ever presented with `cmdValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| clkStable | input | 1 | Memory clock is running and stable |
| cmdAccept | input | 1 | Consumer takes the presented command this cycle |
| cke | output | 1 | Clock-enable to the memory device |
| cmdValid | output | 1 | A command is presented |
| cmdCode | output | 3 | 000 idle, 001 mode-register write, 010 ZQ calibration |
| cmdReg | output | $clog2(NUM_MR) | Mode register index |
| cmdData | output | DATA_W | Mode register value (0 when not a register write) |
| initDone | output | 1 | Sequence complete; stays high until reset |

## Verification
Two events can fall on the same rising edge: the end of an inter-command gap, and a command-accept pulse from the consumer. If the sequencer counted that accept against the command that appears on that edge, a write would be skipped. The bench provokes this by holding `cmdAccept` high across a whole gap and dropping it only once the next command is visible. It then judges the result by checking that `cmdValid` and the register index are still present one cycle later, and that the gap length was unchanged.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_MRW  = 3'd1,
    CMD_ZQC  = 3'd2
  } cmdCode_e;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_WAITCLK,
    ST_MRW,
    ST_GAP,
    ST_ZQ,
    ST_ZQWAIT,
    ST_DONE
  } seqState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic clrCnt;
    logic clrIdx;
    logic incIdx;
    logic setCke;
    logic setDone;
    logic issueMrw;
  } seqStrobes_t;

endpackage

// File: rtl/dram_init_dp.sv
module dram_init_dp
  import dram_init_pkg::*;
#(
  parameter int HOLD_CYCLES = 400000,
  parameter int GAP_CYCLES  = 24,
  parameter int ZQ_CYCLES   = 1024,
  parameter int NUM_MR      = 8,
  parameter int DATA_W      = 18,
  parameter logic [NUM_MR-1:0][DATA_W-1:0] MR_INIT = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  seqStrobes_t                 stb,
  output logic                        holdHit,
  output logic                        gapHit,
  output logic                        zqHit,
  output logic                        lastIdx,
  output logic                        cke,
  output logic                        initDone,
  output logic [$clog2(NUM_MR)-1:0]   cmdReg,
  output logic [DATA_W-1:0]           cmdData
);
  localparam int IDX_W   = $clog2(NUM_MR);
  localparam int TOP_AB  = (HOLD_CYCLES > GAP_CYCLES) ? HOLD_CYCLES : GAP_CYCLES;
  localparam int CNT_TOP = (TOP_AB > ZQ_CYCLES) ? TOP_AB : ZQ_CYCLES;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             ckeQ;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (rst || stb.clrCnt)            cnt <= '0;
    else if (cnt != CNT_W'(CNT_TOP))  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clrIdx) idx <= '0;
    else if (stb.incIdx)   idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ckeQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      if (stb.setCke)  ckeQ  <= 1'b1;
      if (stb.setDone) doneQ <= 1'b1;
    end
  end

  assign holdHit  = (cnt == CNT_W'(HOLD_CYCLES - 1));
  assign gapHit   = (cnt == CNT_W'(GAP_CYCLES - 1));
  assign zqHit    = (cnt == CNT_W'(ZQ_CYCLES - 1));
  assign lastIdx  = (idx == IDX_W'(NUM_MR - 1));
  assign cke      = ckeQ;
  assign initDone = doneQ;
  assign cmdReg   = stb.issueMrw ? idx : '0;
  assign cmdData  = stb.issueMrw ? MR_INIT[idx] : '0;

endmodule

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clkStable,
  input  logic        cmdAccept,
  input  logic        holdHit,
  input  logic        gapHit,
  input  logic        zqHit,
  input  logic        lastIdx,
  output seqStrobes_t stb,
  output logic        cmdValid,
  output logic [2:0]  cmdCode
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HOLD;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    cmdValid  = 1'b0;
    cmdCode   = CMD_IDLE;
    unique case (state)
      ST_HOLD: if (holdHit) begin
        stb.clrCnt = 1'b1;
        nextState  = ST_WAITCLK;
      end
      ST_WAITCLK: if (clkStable) begin
        stb.setCke = 1'b1;
        stb.clrIdx = 1'b1;
        stb.clrCnt = 1'b1;
        nextState  = ST_MRW;
      end
      ST_MRW: begin
        cmdValid     = 1'b1;
        cmdCode      = CMD_MRW;
        stb.issueMrw = 1'b1;
        if (cmdAccept) begin
          stb.clrCnt = 1'b1;
          nextState  = ST_GAP;
        end
      end
      ST_GAP: if (gapHit) begin
        stb.clrCnt = 1'b1;
        if (lastIdx) nextState = ST_ZQ;
        else begin
          stb.incIdx = 1'b1;
          nextState  = ST_MRW;
        end
      end
      ST_ZQ: begin
        cmdValid = 1'b1;
        cmdCode  = CMD_ZQC;
        if (cmdAccept) begin
          stb.clrCnt = 1'b1;
          nextState  = ST_ZQWAIT;
        end
      end
      ST_ZQWAIT: if (zqHit) begin
        stb.setDone = 1'b1;
        nextState   = ST_DONE;
      end
      ST_DONE: nextState = ST_DONE;
      default: nextState = ST_HOLD;
    endcase
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int HOLD_CYCLES = 400000,
  parameter int GAP_CYCLES  = 24,
  parameter int ZQ_CYCLES   = 1024,
  parameter int NUM_MR      = 8,
  parameter int DATA_W      = 18,
  parameter logic [NUM_MR-1:0][DATA_W-1:0] MR_INIT = {
    18'h00400, 18'h00800, 18'h01000, 18'h02000,
    18'h00018, 18'h00200, 18'h00001, 18'h00A50}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clkStable,
  input  logic                      cmdAccept,
  output logic                      cke,
  output logic                      cmdValid,
  output logic [2:0]                cmdCode,
  output logic [$clog2(NUM_MR)-1:0] cmdReg,
  output logic [DATA_W-1:0]         cmdData,
  output logic                      initDone
);
  seqStrobes_t stb;
  logic holdHit, gapHit, zqHit, lastIdx;

  dram_init_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clkStable(clkStable), .cmdAccept(cmdAccept),
    .holdHit(holdHit), .gapHit(gapHit), .zqHit(zqHit), .lastIdx(lastIdx),
    .stb(stb), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  dram_init_dp #(
    .HOLD_CYCLES(HOLD_CYCLES), .GAP_CYCLES(GAP_CYCLES), .ZQ_CYCLES(ZQ_CYCLES),
    .NUM_MR(NUM_MR), .DATA_W(DATA_W), .MR_INIT(MR_INIT)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .holdHit(holdHit), .gapHit(gapHit), .zqHit(zqHit), .lastIdx(lastIdx),
    .cke(cke), .initDone(initDone), .cmdReg(cmdReg), .cmdData(cmdData)
  );

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int HOLD_CYCLES = 400000,
  parameter int GAP_CYCLES  = 24,
  parameter int REG_W       = 3,
  parameter int DATA_W      = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              clkStable,
  input logic              cmdAccept,
  input logic              cke,
  input logic              cmdValid,
  input logic [2:0]        cmdCode,
  input logic [REG_W-1:0]  cmdReg,
  input logic [DATA_W-1:0] cmdData,
  input logic              initDone
);
  logic        rstQ = 1'b0;
  int unsigned ckeLowCnt;
  int unsigned idleCnt;
  logic        sawAccept;

  always_ff @(posedge clk) rstQ <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ckeLowCnt <= 0;
      idleCnt   <= 0;
      sawAccept <= 1'b0;
    end else begin
      if (!cke && ckeLowCnt != 32'hFFFF_FFFF) ckeLowCnt <= ckeLowCnt + 1;
      if (cmdValid) idleCnt <= 0;
      else if (idleCnt != 32'hFFFF_FFFF) idleCnt <= idleCnt + 1;
      if (cmdValid && cmdAccept) sawAccept <= 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rstQ |-> (!cke && !cmdValid && !initDone));

  a_r2_hold_length: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ckeLowCnt >= HOLD_CYCLES);

  a_r3_cke_after_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(clkStable));

  a_r4_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> cke);

  a_r5_cmd_held: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdAccept) |=>
      (cmdValid && $stable(cmdCode) && $stable(cmdReg) && $stable(cmdData)));

  a_r6_min_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmdValid) && sawAccept) |-> idleCnt >= GAP_CYCLES);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    initDone |-> !cmdValid);

  a_r9_code_legal: assert property (@(posedge clk) disable iff (rst)
    cmdValid ? (cmdCode == 3'd1 || cmdCode == 3'd2) : (cmdCode == 3'd0));

endmodule

bind dram_init_seq dram_init_seq_chk #(
  .HOLD_CYCLES(HOLD_CYCLES), .GAP_CYCLES(GAP_CYCLES),
  .REG_W($clog2(NUM_MR)), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .clkStable(clkStable), .cmdAccept(cmdAccept),
  .cke(cke), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdReg(cmdReg),
  .cmdData(cmdData), .initDone(initDone)
);

// File: tb/dram_init_seq_bench.sv
`timescale 1ns/1ps
module dram_init_seq_bench;
  localparam int HOLD = 20;
  localparam int GAP  = 4;
  localparam int ZQW  = 12;
  localparam logic [7:0][17:0] TB_MR = {
    18'h2AAAA, 18'h15555, 18'h0F0F0, 18'h30303,
    18'h00C0C, 18'h11111, 18'h3FFFF, 18'h00123};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkStable = 1'b0;
  logic cmdAccept = 1'b0;
  logic cke, cmdValid, initDone;
  logic [2:0] cmdCode;
  logic [2:0] cmdReg;
  logic [17:0] cmdData;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  dram_init_seq #(
    .HOLD_CYCLES(HOLD), .GAP_CYCLES(GAP), .ZQ_CYCLES(ZQW),
    .NUM_MR(8), .DATA_W(18), .MR_INIT(TB_MR)
  ) u_dram_init_seq (
    .clk(clk), .rst(rst), .clkStable(clkStable), .cmdAccept(cmdAccept),
    .cke(cke), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdReg(cmdReg),
    .cmdData(cmdData), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic applyReset(input bit stable);
    @(negedge clk);
    rst = 1'b1;
    cmdAccept = 1'b0;
    clkStable = stable;
    repeat (3) @(negedge clk);
    check(!cke && !cmdValid && !initDone, "R1", "outputs in reset",
          {cke, cmdValid, initDone}, 0);
    check(cmdCode == 3'd0, "R9", "idle code in reset", cmdCode, 0);
    rst = 1'b0;
  endtask

  // returns edges from release until cke is seen high
  task automatic measureHold(output int edges);
    edges = 0;
    while (!cke && edges < 5000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  // serve all nine commands; stray holds accept high across each gap
  task automatic serveSequence(input int delayBase, input bit stray);
    for (int k = 0; k < 9; k++) begin
      int guard = 0;
      int n;
      while (!cmdValid && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
      if (k < 8) begin
        check(cmdCode == 3'd1, "R4", "register write code", cmdCode, 1);
        check(cmdReg == 3'(k), "R4", "register index order", cmdReg, k);
        check(cmdData == TB_MR[k], "R4", "register value", cmdData, TB_MR[k]);
        check(cke, "R4", "cke during write", cke, 1);
      end else begin
        check(cmdCode == 3'd2, "R7", "calibration code", cmdCode, 2);
      end
      for (int d = 0; d < (delayBase + k) % 3; d++) begin
        logic [2:0] c0 = cmdCode;
        logic [2:0] r0 = cmdReg;
        logic [17:0] v0 = cmdData;
        @(negedge clk);
        check(cmdValid && cmdCode == c0 && cmdReg == r0 && cmdData == v0,
              "R5", "command held", {cmdValid, cmdCode, cmdReg}, {1'b1, c0, r0});
      end
      cmdAccept = 1'b1;
      @(negedge clk);
      if (!stray) cmdAccept = 1'b0;
      n = 0;
      if (k < 8) begin
        while (!cmdValid && n < 1000) begin
          n++;
          @(negedge clk);
        end
        check(n == GAP, "R6", "gap length", n, GAP);
        if (stray) begin
          // accept was high on the edge that ended the gap: must not count
          cmdAccept = 1'b0;
          @(negedge clk);
          check(cmdValid && cmdReg == 3'(k + 1 < 8 ? k + 1 : 0),
                "R6", "accept during gap ignored", {cmdValid, cmdReg},
                {1'b1, 3'(k + 1 < 8 ? k + 1 : 0)});
        end
      end else begin
        cmdAccept = 1'b0;
        while (!initDone && n < 1000) begin
          check(!cmdValid, "R8", "no command while calibrating", cmdValid, 0);
          n++;
          @(negedge clk);
        end
        check(n == ZQW, "R8", "calibration wait", n, ZQW);
      end
    end
  endtask

  task automatic testPowerUp();
    int e;
    applyReset(1'b1);
    measureHold(e);
    check(e == HOLD + 1, "R2", "cke rise edge count", e, HOLD + 1);
    serveSequence(0, 1'b0);
  endtask

  task automatic testDoneSticky();
    for (int i = 0; i < 30; i++) begin
      cmdAccept = i[0];
      @(negedge clk);
      check(initDone && !cmdValid && cmdCode == 3'd0, "R8", "done stays, no command",
            {initDone, cmdValid, cmdCode}, {1'b1, 1'b0, 3'd0});
    end
    cmdAccept = 1'b0;
  endtask

  task automatic testClockGate();
    applyReset(1'b0);
    cmdAccept = 1'b1;  // stray accept while nothing is presented (R6)
    for (int i = 0; i < HOLD + 30; i++) begin
      @(negedge clk);
      check(!cke && !cmdValid, "R3", "cke low without stable clock", {cke, cmdValid}, 0);
    end
    cmdAccept = 1'b0;
    clkStable = 1'b1;
    @(negedge clk);
    check(cke, "R3", "cke one edge after stable", cke, 1);
    serveSequence(2, 1'b1);
  endtask

  task automatic testMidReset();
    int e;
    applyReset(1'b1);
    repeat (HOLD + 3) @(negedge clk);
    check(cmdValid && cmdReg == 3'd0, "R4", "first write presented", cmdReg, 0);
    rst = 1'b1;
    @(negedge clk);
    check(!cke && !cmdValid && !initDone, "R1", "mid-sequence reset",
          {cke, cmdValid, initDone}, 0);
    rst = 1'b0;
    measureHold(e);
    check(e == HOLD + 1, "R2", "hold after mid reset", e, HOLD + 1);
    serveSequence(1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    testPowerUp();
    testDoneSticky();
    testClockGate();
    testDoneSticky();
    testMidReset();
    testDoneSticky();
    summary();
  end

endmodule